// File: doc/BRIEF.md
# Two-Wire Target with Byte Storage

This block is a two-wire serial bus (I2C) target that sits in front of a 2^ADDR_W by 8 storage array (256 bytes by default). It samples the bus clock and data lines through synchronizers running on a fast system clock. It finds START and STOP conditions by watching SDA while SCL is high, and shifts bytes most significant bit first on the SCL rising edges. It pulls SDA low through a single open-drain enable output, both to acknowledge and to return read data.

A controller first sends the 7-bit target address and a direction bit. For a write, the next byte sets a word pointer, and each byte after that is stored at the pointer, which then steps forward. For a read, bytes are returned from the pointer for as long as the controller acknowledges them. The number of bytes stored in one write transfer is capped. The cap is chosen by a mode input that is sampled at START: one limit applies to plain writes and a larger one to page writes. Reads have no length cap. Bus timing is scaled so that each SCL phase spans several system clocks, as standard-speed operation requires.

Top module: `i2c_bytemem_target`

## Requirements
- R1: START is recognized when SDA falls while SCL stays high. STOP is recognized when SDA rises while SCL stays high. After a STOP the block releases SDA and ignores clock pulses until the next START, so a byte clocked without a START gets no acknowledge.
- R2: The first byte after a START is the address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The block pulls SDA low during the ninth clock only when bits 7..1 equal TARGET_ADDR. On a mismatch it gives no acknowledge, and it neither stores nor answers anything until the next START.
- R3: In a write transfer the second byte loads the word pointer and is acknowledged.
- R4: Each accepted data byte is stored at the word pointer and is acknowledged. The pointer then advances by one and wraps from its highest value to 0.
- R5: With page_sel low at START, at most NORM_LIMIT (default 7) data bytes are accepted per transfer. Later bytes are neither acknowledged nor stored, and the pointer does not move for them.
- R6: With page_sel high at START, at most PAGE_LIMIT (default 8) data bytes are accepted per transfer. Later bytes are neither acknowledged nor stored.
- R7: In a read transfer the block returns the bytes at the pointer MSB first and advances the pointer (with wrap) after each byte. The number of bytes read is not limited.
- R8: When the controller does not acknowledge a read byte (SDA high on the ninth clock), the block stops driving SDA until the next START or STOP.
- R9: A repeated START clears the count of data bytes and expects a new address byte. The word pointer is kept, so a pointer write followed by a repeated START and a read returns data from that pointer.
- R10: sda_oe is low out of reset, and it changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| page_sel | input | 1 | Write cap select, sampled at START: 1 = page limit, 0 = normal limit |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The embedded properties check on every cycle the following:
- sda_oe only moves while SCL is low.
- The write count never passes the cap of the latched mode.
- The pointer only steps by one, except when it is loaded.
- Every stored byte is followed by an acknowledge.
- START and STOP return the sequencer to a known, released state.

Other behaviour shows only in the bench scenarios:
- Correct byte contents after wrap-around.
- Bytes past the cap that leave storage untouched.
- A bus that stays released after a controller NACK.
- A pointer kept across a repeated START.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WADDR,
      ST_WDATA,
      ST_READ,
      ST_SKIP
   } tgt_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else if (STAGES == 1) chain <= d_in;
            else chain <= {chain[STAGES-2:0], d_in};
         end
         assign q_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2cbm_cond.sv
module i2cbm_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start_evt,
   output logic stop_evt,
   output logic rise_evt,
   output logic fall_evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
   assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;
   assign rise_evt  = ~scl_q & scl_s;
   assign fall_evt  = scl_q & ~scl_s;
endmodule

// File: rtl/i2cbm_store.sv
module i2cbm_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_bytemem_target.sv
module i2c_bytemem_target
   import i2cbm_pkg::*;
#(
   parameter logic [6:0] TARGET_ADDR = 7'h50,
   parameter int          ADDR_W      = 8,
   parameter int          NORM_LIMIT  = 7,
   parameter int          PAGE_LIMIT  = 8,
   parameter int          SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   input  logic page_sel,
   output logic sda_oe
);
   localparam int MAX_LIMIT = (NORM_LIMIT > PAGE_LIMIT) ? NORM_LIMIT : PAGE_LIMIT;
   localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

   generate
      if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
         $error("ADDR_W must lie in 1..8");
      end
      if (NORM_LIMIT < 1 || PAGE_LIMIT < 1) begin : g_bad_lim
         $error("write limits must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic scl_s, sda_s;
   logic start_evt, stop_evt, rise_evt, fall_evt;

   i2cbm_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s));
   i2cbm_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));

   i2cbm_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .rise_evt(rise_evt), .fall_evt(fall_evt));

   tgt_state_e          state;
   logic [3:0]          bitcnt;
   logic                ack_slot;
   logic                rw_q;
   logic                mode_q;
   logic                mnack;
   logic                oe_q;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-2:0]   txreg;
   logic [ADDR_W-1:0]   ptr;
   logic [CNT_W-1:0]    wcount;
   logic [CNT_W-1:0]    cap_now;
   logic [BYTE_W-1:0]   rd_data;
   logic                mem_we;
   logic                byte_done;

   assign cap_now   = mode_q ? CNT_W'(PAGE_LIMIT) : CNT_W'(NORM_LIMIT);
   assign byte_done = fall_evt && !ack_slot && (bitcnt == 4'd8);
   assign mem_we    = byte_done && (state == ST_WDATA) && (wcount < cap_now);

   i2cbm_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
      .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
      .raddr(ptr), .rdata(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         ack_slot <= 1'b0;
         rw_q     <= 1'b0;
         mode_q   <= 1'b0;
         mnack    <= 1'b1;
         oe_q     <= 1'b0;
         shreg    <= '0;
         txreg    <= '0;
         ptr      <= '0;
         wcount   <= '0;
      end else if (start_evt) begin
         state    <= ST_ADDR;
         bitcnt   <= '0;
         ack_slot <= 1'b0;
         oe_q     <= 1'b0;
         wcount   <= '0;
         mode_q   <= page_sel;
      end else if (stop_evt) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         ack_slot <= 1'b0;
         oe_q     <= 1'b0;
      end else if (rise_evt) begin
         if (!ack_slot && bitcnt < 4'd8) begin
            if (state inside {ST_ADDR, ST_WADDR, ST_WDATA}) begin
               shreg  <= {shreg[BYTE_W-2:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end else if (state == ST_READ) begin
               bitcnt <= bitcnt + 4'd1;
            end
         end else if (ack_slot && state == ST_READ) begin
            mnack <= sda_s;
         end
      end else if (fall_evt) begin
         if (ack_slot) begin
            ack_slot <= 1'b0;
            bitcnt   <= '0;
            oe_q     <= 1'b0;
            case (state)
               ST_ADDR: begin
                  if (rw_q) begin
                     state <= ST_READ;
                     txreg <= rd_data[BYTE_W-2:0];
                     oe_q  <= ~rd_data[BYTE_W-1];
                     ptr   <= ptr + ADDR_W'(1);
                  end else begin
                     state <= ST_WADDR;
                  end
               end
               ST_WADDR: state <= ST_WDATA;
               ST_READ: begin
                  if (mnack) begin
                     state <= ST_SKIP;
                  end else begin
                     txreg <= rd_data[BYTE_W-2:0];
                     oe_q  <= ~rd_data[BYTE_W-1];
                     ptr   <= ptr + ADDR_W'(1);
                  end
               end
               default: ;
            endcase
         end else if (bitcnt == 4'd8) begin
            case (state)
               ST_ADDR: begin
                  if (shreg[BYTE_W-1:1] == TARGET_ADDR) begin
                     ack_slot <= 1'b1;
                     oe_q     <= 1'b1;
                     rw_q     <= shreg[0];
                  end else begin
                     state <= ST_SKIP;
                  end
               end
               ST_WADDR: begin
                  ptr      <= shreg[ADDR_W-1:0];
                  ack_slot <= 1'b1;
                  oe_q     <= 1'b1;
               end
               ST_WDATA: begin
                  ack_slot <= 1'b1;
                  if (wcount < cap_now) begin
                     oe_q   <= 1'b1;
                     ptr    <= ptr + ADDR_W'(1);
                     wcount <= wcount + CNT_W'(1);
                  end
               end
               ST_READ: begin
                  ack_slot <= 1'b1;
                  oe_q     <= 1'b0;
               end
               default: ;
            endcase
         end else if (state == ST_READ) begin
            oe_q  <= ~txreg[BYTE_W-2];
            txreg <= {txreg[BYTE_W-3:0], 1'b0};
         end
      end
   end

   assign sda_oe = oe_q;

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_s); // R10
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state == ST_IDLE) && !oe_q); // R1
   AST_WRITE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      wcount <= cap_now); // R5
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr)) && ($past(state) != ST_WADDR) |-> ptr == $past(ptr) + ADDR_W'(1)); // R4
   AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> oe_q); // R4
   AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !oe_q); // R8
   AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state == ST_ADDR) && (wcount == '0) && !oe_q); // R9
endmodule

// File: tb/i2c_bytemem_target_test.sv
module i2c_bytemem_target_test;
   localparam int Q = 6;
   localparam logic [6:0] TGT = 7'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic page_sel = 1'b0;
   logic sda_oe;
   logic sda_line;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] model [256];
   bit known [256];

   assign sda_line = m_sda & ~sda_oe;
   always #2 clk = ~clk;

   i2c_bytemem_target #(.TARGET_ADDR(TGT)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .page_sel(page_sel), .sda_oe(sda_oe));

   function automatic int cap_of(input bit pg);
      return pg ? 8 : 7;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; qw();
      m_sda = 1'b0; qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b0; qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; qw();
      m_scl = 1'b1; qw();
      m_sda = 1'b1; qw();
   endtask

   task automatic send_bit(input bit b);
      m_sda = b; qw();
      m_scl = 1'b1; qw(); qw();
      m_scl = 1'b0; qw();
   endtask

   task automatic recv_bit(output bit b);
      bit early;
      m_sda = 1'b1; qw();
      m_scl = 1'b1; @(negedge clk); early = sda_line;
      qw(); b = sda_line; qw();
      chk(early == b, "R10 stable while SCL high", b, early);
      m_scl = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] d, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(r);
      qw();
      ack = !r;
   endtask

   task automatic read_byte(input bit give_ack, output logic [7:0] d);
      bit r;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(r);
         qw();
         d[i] = r;
      end
      send_bit(!give_ack);
   endtask

   task automatic do_write(input logic [7:0] wa, input int n, input bit pg, input string req);
      bit ack;
      logic [7:0] d;
      logic [7:0] p;
      page_sel = pg;
      bus_start();
      write_byte({TGT, 1'b0}, ack);
      chk(ack, "R2 address ack", ack, 1);
      write_byte(wa, ack);
      chk(ack, "R3 pointer ack", ack, 1);
      p = wa;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         write_byte(d, ack);
         chk(ack == (i < cap_of(pg)), req, ack, int'(i < cap_of(pg)));
         if (i < cap_of(pg)) begin
            model[p] = d;
            known[p] = 1'b1;
            p = p + 8'd1;
         end
      end
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] wa, input int n, input string req);
      bit ack;
      logic [7:0] d;
      logic [7:0] p;
      bus_start();
      write_byte({TGT, 1'b0}, ack);
      chk(ack, "R2 address ack", ack, 1);
      write_byte(wa, ack);
      chk(ack, "R3 pointer ack", ack, 1);
      bus_rstart();
      write_byte({TGT, 1'b1}, ack);
      chk(ack, "R9 read address after repeated start", ack, 1);
      p = wa;
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, d);
         if (known[p]) chk(d == model[p], req, d, model[p]);
         p = p + 8'd1;
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ack;
      bit r;
      int ones;
      logic [7:0] d;
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) begin
         known[i] = 1'b0;
         model[i] = 8'h00;
      end
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R10 idle after reset", sda_oe, 0);

      // R6 fill with page writes, then a long read (R7)
      for (int k = 0; k < 5; k++) do_write(8'(k * 8), 8, 1'b1, "R6 page fill");
      do_read(8'h00, 40, "R7 long sequential read");

      // R5 normal cap: bytes 8 and 9 neither acked nor stored
      do_write(8'h27, 4, 1'b1, "R6 prefill");
      do_write(8'h20, 9, 1'b0, "R5 normal cap");
      do_read(8'h20, 11, "R5 bytes past cap not stored");

      // R6 page cap
      do_write(8'h48, 3, 1'b0, "R5 prefill");
      do_write(8'h40, 10, 1'b1, "R6 page cap");
      do_read(8'h40, 11, "R6 bytes past cap not stored");

      // R4 write wrap and R7 read wrap
      do_write(8'hFE, 4, 1'b1, "R4 wrap write");
      do_read(8'hFE, 4, "R4 wrap store");
      do_read(8'hFF, 3, "R7 read wrap");

      // R2 address mismatch ignored
      bus_start();
      write_byte({7'h23, 1'b0}, ack);
      chk(!ack, "R2 mismatch nack", ack, 0);
      write_byte(8'h05, ack);
      chk(!ack, "R2 mismatch pointer ignored", ack, 0);
      write_byte(~model[5], ack);
      bus_stop();
      do_read(8'h05, 1, "R2 mismatch left storage");

      // R8 controller NACK releases SDA
      bus_start();
      write_byte({TGT, 1'b0}, ack);
      write_byte(8'h00, ack);
      bus_rstart();
      write_byte({TGT, 1'b1}, ack);
      read_byte(1'b0, d);
      chk(d == model[0], "R8 byte before nack", d, model[0]);
      ones = 0;
      for (int i = 0; i < 9; i++) begin
         recv_bit(r);
         qw();
         ones += int'(r);
      end
      chk(ones == 9, "R8 released after nack", ones, 9);
      bus_stop();

      // R1 no response without START
      write_byte({TGT, 1'b0}, ack);
      chk(!ack, "R1 no ack without start", ack, 0);
      chk(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);

      // R9 repeated start clears byte count
      page_sel = 1'b0;
      bus_start();
      write_byte({TGT, 1'b0}, ack);
      write_byte(8'h60, ack);
      for (int i = 0; i < 5; i++) begin
         d = 8'($urandom);
         write_byte(d, ack);
         model[8'h60 + i] = d;
         known[8'h60 + i] = 1'b1;
      end
      bus_rstart();
      write_byte({TGT, 1'b0}, ack);
      chk(ack, "R9 address after repeated start", ack, 1);
      write_byte(8'h70, ack);
      for (int i = 0; i < 7; i++) begin
         d = 8'($urandom);
         write_byte(d, ack);
         chk(ack, "R9 count cleared", ack, 1);
         model[8'h70 + i] = d;
         known[8'h70 + i] = 1'b1;
      end
      bus_stop();
      do_read(8'h70, 7, "R9 stored after repeated start");
      do_read(8'h60, 5, "R4 stored before repeated start");

      // random mix
      for (int t = 0; t < 10; t++) begin
         logic [7:0] wa;
         int n;
         bit pg;
         wa = 8'($urandom);
         n = 1 + int'($urandom % 10);
         pg = 1'($urandom);
         do_write(wa, n, pg, pg ? "R6 random" : "R5 random");
         do_read(wa, n + 1, "R7 random readback");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule